// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block moves packet bytes between a host-facing data port and packet memory one access at a time. The block keeps two registers: a remote address and a remaining byte count. The host loads both before a transfer. After that, every strobe on the data port reads or writes packet memory at the current remote address and then advances the address by the width of the access. When the address reaches the ring stop it jumps back to the ring start. The count is reduced by the same amount on each access. When the count is used up, the block raises a one-cycle pulse that sets the "remote DMA complete" interrupt status bit in the surrounding controller.

The access width depends on two inputs:
- A 32-bit (wide) strobe always moves four bytes.
- A narrow strobe moves two bytes when the data-width configuration bit is set, and one byte when it is clear.

Multi-byte accesses use an even address and little-endian byte lanes. Only two address windows reach memory. Reads outside them return all ones, and writes outside them go nowhere. A command strobe issued while the count is already zero raises the completion pulse at once, so a zero-length transfer still finishes.

Top module: `rdma_port_engine`

## Requirements
- R1: An access that is not ignored advances the remote address by its step. The step is 4 when `acc_wide_i` is high, 2 when `acc_wide_i` is low and `cfg_word16_i` is high, and 1 otherwise. The new address is visible on `cur_addr_o` after the clock edge that takes the strobe. The address wraps modulo 2^16.
- R2: If the advanced address equals `ring_stop_pg_i` × 256, the remote address is reloaded with `ring_start_pg_i` × 256 instead.
- R3: On an access that is not ignored, a count that is less than or equal to the step becomes zero, and `rdc_set_o` pulses high for exactly the one cycle after the strobe edge. A larger count is reduced by the step, with no pulse.
- R4: A write strobe while the count is zero is ignored entirely: no memory request, no change of address or count, and no completion pulse.
- R5: Accesses with a step of 2 or 4 present the remote address with bit 0 cleared on `mem_addr_o`. A 1-byte access presents it unchanged. The stored address itself is changed only by stepping.
- R6: The byte lanes are little-endian. Lane k (bits 8k+7:8k) of the write data goes to byte address `mem_addr_o`+k. Read lane k comes from byte address `mem_addr_o`+k. Lanes at or above the step read as zero.
- R7: Memory is reached only when the even-adjusted address is below 32, or lies from 16384 up to and including 49151. For any other address there is no `mem_req_o`, reads return 0xFF in every lane within the step, and writes are discarded. Address and count still advance.
- R8: A `dma_cmd_i` strobe while the count is zero pulses `rdc_set_o` in the next cycle. With a nonzero count it does not.
- R9: `rd_valid_o` is high for exactly the one cycle after each read strobe, and `rd_data_o` carries the result in that cycle. No `rd_valid_o` follows a write.
- R10: After reset the address and count are zero, and `rd_valid_o`, `rdc_set_o` and `mem_req_o` are low.
- R11: `ld_addr_i` and `ld_cnt_i` load the address and count registers. A load in the same cycle as an access overrides the stepped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_word16_i | input | 1 | Narrow accesses move 2 bytes when high, 1 byte when low |
| ring_start_pg_i | input | 8 | First page of the receive ring |
| ring_stop_pg_i | input | 8 | Page one past the end of the ring |
| ld_addr_i | input | 1 | Load the remote address |
| ld_addr_val_i | input | 16 | Value for the address load |
| ld_cnt_i | input | 1 | Load the remaining count |
| ld_cnt_val_i | input | 16 | Value for the count load |
| dma_cmd_i | input | 1 | A remote read or write command was issued |
| acc_valid_i | input | 1 | Data port strobe |
| acc_write_i | input | 1 | Strobe is a write |
| acc_wide_i | input | 1 | Strobe is a 4-byte access |
| acc_wdata_i | input | 32 | Write data, little-endian lanes |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 32 | Read result |
| cur_addr_o | output | 16 | Current remote address |
| cur_cnt_o | output | 16 | Remaining byte count |
| rdc_set_o | output | 1 | Pulse that sets the remote-DMA-complete status |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Byte address of lane 0 |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |

## Verification
The bench builds the block with its default parameters: 16-bit address and count, 8-bit pages and four byte lanes. The window limits are 32, 16384 and 49152. With these values every window edge (31/32, 16383/16384, 49151/49152) is a reachable address. A ring from page 0x40 to 0x60 sits inside the upper window, so the wrap happens on memory that really exists. The count range lets small loaded counts show each completion boundary for steps of 1, 2 and 4.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    // Number of bytes moved by one port access
    function automatic logic [2:0] step_of(input logic wide, input logic word16);
        if (wide)
            return 3'd4;
        else if (word16)
            return 3'd2;
        else
            return 3'd1;
    endfunction

    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/rdma_win_decode.sv
module rdma_win_decode #(
    parameter int ADDR_W  = 16,
    parameter int LOW_END = 32,
    parameter int WIN_LO  = 16384,
    parameter int WIN_HI  = 49152
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W:0] LOW_C = (ADDR_W+1)'(LOW_END);
    localparam logic [ADDR_W:0] LO_C  = (ADDR_W+1)'(WIN_LO);
    localparam logic [ADDR_W:0] HI_C  = (ADDR_W+1)'(WIN_HI);

    logic [ADDR_W:0] a_ext;

    always_comb begin
        a_ext = {1'b0, addr_i};
        hit_o = (a_ext < LOW_C) || ((a_ext >= LO_C) && (a_ext < HI_C));
    end
endmodule

// File: rtl/rdma_advance.sv
module rdma_advance #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int STEP_W     = 3,
    parameter int PAGE_SHIFT = 8
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [CNT_W-1:0]             cnt_i,
    input  logic [STEP_W-1:0]            step_i,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] start_pg_i,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] stop_pg_i,
    output logic [ADDR_W-1:0]            addr_nx_o,
    output logic [CNT_W-1:0]             cnt_nx_o,
    output logic                         done_o
);
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] ring_lo;
    logic [ADDR_W-1:0] ring_hi;

    always_comb begin
        ring_lo   = {start_pg_i, {PAGE_SHIFT{1'b0}}};
        ring_hi   = {stop_pg_i, {PAGE_SHIFT{1'b0}}};
        sum       = addr_i + ADDR_W'(step_i);
        addr_nx_o = (sum == ring_hi) ? ring_lo : sum;
        done_o    = (cnt_i <= CNT_W'(step_i));
        cnt_nx_o  = done_o ? '0 : (cnt_i - CNT_W'(step_i));
    end
endmodule

// File: rtl/rdma_lane_mux.sv
module rdma_lane_mux #(
    parameter int LANES  = 4,
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0]  step_i,
    input  logic               hit_i,
    input  logic [8*LANES-1:0] data_i,
    output logic [8*LANES-1:0] data_o
);
    import rdma_pkg::*;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [STEP_W-1:0] LANE_IDX = STEP_W'(k);
        always_comb begin
            if (LANE_IDX >= step_i)
                data_o[8*k +: 8] = 8'h00;
            else if (hit_i)
                data_o[8*k +: 8] = data_i[8*k +: 8];
            else
                data_o[8*k +: 8] = FILL_BYTE;
        end
    end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PAGE_SHIFT = 8,
    parameter int LANES      = 4,
    parameter int LOW_END    = 32,
    parameter int WIN_LO     = 16384,
    parameter int WIN_HI     = 49152
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         cfg_word16_i,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] ring_start_pg_i,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] ring_stop_pg_i,
    input  logic                         ld_addr_i,
    input  logic [ADDR_W-1:0]            ld_addr_val_i,
    input  logic                         ld_cnt_i,
    input  logic [CNT_W-1:0]             ld_cnt_val_i,
    input  logic                         dma_cmd_i,
    input  logic                         acc_valid_i,
    input  logic                         acc_write_i,
    input  logic                         acc_wide_i,
    input  logic [8*LANES-1:0]           acc_wdata_i,
    output logic                         rd_valid_o,
    output logic [8*LANES-1:0]           rd_data_o,
    output logic [ADDR_W-1:0]            cur_addr_o,
    output logic [CNT_W-1:0]             cur_cnt_o,
    output logic                         rdc_set_o,
    output logic                         mem_req_o,
    output logic                         mem_we_o,
    output logic [ADDR_W-1:0]            mem_addr_o,
    output logic [LANES-1:0]             mem_be_o,
    output logic [8*LANES-1:0]           mem_wdata_o,
    input  logic [8*LANES-1:0]           mem_rdata_i
);
    localparam int STEP_W = $clog2(LANES) + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              rd_pend;
        logic              rd_hit;
        logic [STEP_W-1:0] rd_step;
        logic              rdc;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] base;
    logic              hit;
    logic              blocked;
    logic              fire;
    logic [ADDR_W-1:0] adv_addr;
    logic [CNT_W-1:0]  adv_cnt;
    logic              adv_done;

    // access width and even-forced lane-0 address
    always_comb begin
        if (acc_wide_i)
            step = STEP_W'(LANES);
        else if (cfg_word16_i)
            step = STEP_W'(2);
        else
            step = STEP_W'(1);
        base    = (step != STEP_W'(1)) ? {st_q.addr[ADDR_W-1:1], 1'b0} : st_q.addr;
        blocked = acc_write_i && (st_q.cnt == '0);
        fire    = acc_valid_i && !blocked;
    end

    rdma_win_decode #(
        .ADDR_W (ADDR_W),
        .LOW_END(LOW_END),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) win_i (
        .addr_i(base),
        .hit_o (hit)
    );

    rdma_advance #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .STEP_W    (STEP_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) adv_i (
        .addr_i    (st_q.addr),
        .cnt_i     (st_q.cnt),
        .step_i    (step),
        .start_pg_i(ring_start_pg_i),
        .stop_pg_i (ring_stop_pg_i),
        .addr_nx_o (adv_addr),
        .cnt_nx_o  (adv_cnt),
        .done_o    (adv_done)
    );

    // write lanes: unused lanes forced to zero
    rdma_lane_mux #(
        .LANES (LANES),
        .STEP_W(STEP_W)
    ) wr_mux_i (
        .step_i(step),
        .hit_i (1'b1),
        .data_i(acc_wdata_i),
        .data_o(mem_wdata_o)
    );

    // read lanes: fill outside the windows, zero above the step
    rdma_lane_mux #(
        .LANES (LANES),
        .STEP_W(STEP_W)
    ) rd_mux_i (
        .step_i(st_q.rd_step),
        .hit_i (st_q.rd_hit),
        .data_i(mem_rdata_i),
        .data_o(rd_data_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_be
        localparam logic [STEP_W-1:0] LANE_IDX = STEP_W'(k);
        assign mem_be_o[k] = mem_req_o && (LANE_IDX < step);
    end

    always_comb begin
        mem_req_o  = fire && hit;
        mem_we_o   = acc_write_i;
        mem_addr_o = base;

        st_d         = st_q;
        st_d.rd_pend = acc_valid_i && !acc_write_i;
        st_d.rd_hit  = hit;
        st_d.rd_step = step;
        st_d.rdc     = 1'b0;

        if (fire) begin
            st_d.addr = adv_addr;
            st_d.cnt  = adv_cnt;
            st_d.rdc  = adv_done;
        end
        if (dma_cmd_i && (st_q.cnt == '0))
            st_d.rdc = 1'b1;
        if (ld_addr_i)
            st_d.addr = ld_addr_val_i;
        if (ld_cnt_i)
            st_d.cnt = ld_cnt_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_valid_o = st_q.rd_pend;
    assign cur_addr_o = st_q.addr;
    assign cur_cnt_o  = st_q.cnt;
    assign rdc_set_o  = st_q.rdc;

    // R9: a read strobe is answered in the next cycle
    a_r9_read_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i && !acc_write_i |=> rd_valid_o);

    // R9: no read result without a read strobe one cycle earlier
    a_r9_read_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(acc_valid_i && !acc_write_i));

    // R4: a write with nothing left reaches no memory
    a_r4_no_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i && acc_write_i && (cur_cnt_o == '0) |-> !mem_req_o);

    // R4: and leaves the registers and the pulse alone
    a_r4_state_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i && acc_write_i && (cur_cnt_o == '0) && !ld_addr_i && !ld_cnt_i && !dma_cmd_i
        |=> $stable(cur_addr_o) && $stable(cur_cnt_o) && !rdc_set_o);

    // R5: multi-byte requests are even
    a_r5_even_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o && (acc_wide_i || cfg_word16_i) |-> !mem_addr_o[0]);

    // R3: completion leaves a zero count unless a load intervened
    a_r3_done_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdc_set_o && !$past(ld_cnt_i) |-> (cur_cnt_o == '0));

    // R3: a live access always lowers a nonzero count
    a_r3_count_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i && (cur_cnt_o != '0) && !ld_cnt_i |=> (cur_cnt_o < $past(cur_cnt_o)));
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word16 = 1'b0;
    logic [7:0]  ring_start = 8'h40;
    logic [7:0]  ring_stop = 8'h60;
    logic        ld_addr = 1'b0;
    logic [15:0] ld_addr_val = '0;
    logic        ld_cnt = 1'b0;
    logic [15:0] ld_cnt_val = '0;
    logic        dma_cmd = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_wide = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [15:0] cur_addr;
    logic [15:0] cur_cnt;
    logic        rdc_set;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;

    logic [7:0]  model_mem [int];
    logic [7:0]  ref_mem [int];
    logic [15:0] e_addr = '0;
    logic [15:0] e_cnt = '0;

    always #4 clk = ~clk;

    rdma_port_engine dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cfg_word16_i   (cfg_word16),
        .ring_start_pg_i(ring_start),
        .ring_stop_pg_i (ring_stop),
        .ld_addr_i      (ld_addr),
        .ld_addr_val_i  (ld_addr_val),
        .ld_cnt_i       (ld_cnt),
        .ld_cnt_val_i   (ld_cnt_val),
        .dma_cmd_i      (dma_cmd),
        .acc_valid_i    (acc_valid),
        .acc_write_i    (acc_write),
        .acc_wide_i     (acc_wide),
        .acc_wdata_i    (acc_wdata),
        .rd_valid_o     (rd_valid),
        .rd_data_o      (rd_data),
        .cur_addr_o     (cur_addr),
        .cur_cnt_o      (cur_cnt),
        .rdc_set_o      (rdc_set),
        .mem_req_o      (mem_req),
        .mem_we_o       (mem_we),
        .mem_addr_o     (mem_addr),
        .mem_be_o       (mem_be),
        .mem_wdata_o    (mem_wdata),
        .mem_rdata_i    (mem_rdata)
    );

    // single-cycle synchronous byte-lane memory
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k])
                        model_mem[(int'(mem_addr) + k) & 16'hFFFF] = mem_wdata[8*k +: 8];
            end else begin
                logic [31:0] tmp;
                for (int k = 0; k < 4; k++) begin
                    int a;
                    a = (int'(mem_addr) + k) & 16'hFFFF;
                    tmp[8*k +: 8] = model_mem.exists(a) ? model_mem[a] : 8'h00;
                end
                mem_rdata <= tmp;
            end
        end
    end

    function automatic logic [7:0] ref_byte(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    function automatic bit in_win(input int a);
        return (a < 32) || (a >= 16384 && a < 49152);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        ld_addr = 1'b1; ld_addr_val = a;
        ld_cnt = 1'b1;  ld_cnt_val = c;
        @(negedge clk);
        ld_addr = 1'b0; ld_cnt = 1'b0;
        e_addr = a; e_cnt = c;
        chk(cur_addr == a && cur_cnt == c, "R11 load", {cur_addr, cur_cnt}, {a, c});
    endtask

    task automatic port_op(input bit wr, input bit wide, input bit w16, input logic [31:0] wd);
        int step;
        int base;
        bit ok;
        bit blocked;
        bit exp_req;
        bit exp_rdc;
        logic [31:0] exp_data;
        int sum;

        step    = wide ? 4 : (w16 ? 2 : 1);
        base    = (step > 1) ? (int'(e_addr) & 16'hFFFE) : int'(e_addr);
        ok      = in_win(base);
        blocked = wr && (e_cnt == 0);
        exp_req = ok && !blocked;
        exp_data = '0;
        for (int k = 0; k < step; k++)
            exp_data[8*k +: 8] = ok ? ref_byte((base + k) & 16'hFFFF) : 8'hFF;

        @(negedge clk);
        cfg_word16 = w16; acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_wdata = wd;
        #1;
        chk(mem_req == exp_req, "R7/R4 request", mem_req, exp_req);
        if (exp_req)
            chk(int'(mem_addr) == base, "R5 lane-0 address", mem_addr, base);
        if (exp_req && wr)
            for (int k = 0; k < step; k++)
                chk(mem_be[k] && mem_wdata[8*k +: 8] == wd[8*k +: 8], "R6 write lane",
                    mem_wdata[8*k +: 8], wd[8*k +: 8]);
        @(negedge clk);
        acc_valid = 1'b0;

        if (exp_req && wr)
            for (int k = 0; k < step; k++)
                ref_mem[(base + k) & 16'hFFFF] = wd[8*k +: 8];

        exp_rdc = 1'b0;
        if (!blocked) begin
            sum = (int'(e_addr) + step) & 16'hFFFF;
            if (sum == (int'(ring_stop) << 8))
                e_addr = {ring_start, 8'h00};
            else
                e_addr = 16'(sum);
            if (int'(e_cnt) <= step) begin
                e_cnt = '0; exp_rdc = 1'b1;
            end else begin
                e_cnt = e_cnt - 16'(step);
            end
        end
        chk(rd_valid == !wr, "R9 read valid", rd_valid, !wr);
        if (!wr)
            chk(rd_data == exp_data, "R6/R7 read data", rd_data, exp_data);
        chk(cur_addr == e_addr, "R1/R2 address", cur_addr, e_addr);
        chk(cur_cnt == e_cnt, "R3 count", cur_cnt, e_cnt);
        chk(rdc_set == exp_rdc, "R3/R4 completion pulse", rdc_set, exp_rdc);
    endtask

    task automatic cmd_op(input bit exp_pulse);
        @(negedge clk);
        dma_cmd = 1'b1;
        @(negedge clk);
        dma_cmd = 1'b0;
        chk(rdc_set == exp_pulse, "R8 command pulse", rdc_set, exp_pulse);
        @(negedge clk);
        chk(rdc_set == 1'b0, "R8 pulse one cycle", rdc_set, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        chk(cur_addr == 0 && cur_cnt == 0, "R10 reset regs", {cur_addr, cur_cnt}, 0);
        chk(!rd_valid && !rdc_set && !mem_req, "R10 reset outputs", {rd_valid, rdc_set, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: write with zero count is ignored
        load(16'h4000, 16'd0);
        port_op(1'b1, 1'b0, 1'b0, 32'h0000_00AA);
        // R3: read with zero count still completes
        port_op(1'b0, 1'b0, 1'b0, 32'h0);

        // R8
        cmd_op(1'b1);
        load(16'h4000, 16'd5);
        cmd_op(1'b0);

        // R6 little-endian lanes
        load(16'h4010, 16'd8);
        port_op(1'b1, 1'b1, 1'b0, 32'hA1B2_C3D4);
        load(16'h4010, 16'd8);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        // R5 odd address with 2-byte access
        load(16'h4011, 16'd8);
        port_op(1'b0, 1'b0, 1'b1, 32'h0);
        chk(cur_addr == 16'h4013, "R5 stored address not forced", cur_addr, 16'h4013);

        // R2 ring wrap
        load(16'h5FFC, 16'd100);
        port_op(1'b1, 1'b1, 1'b0, 32'h1122_3344);
        chk(cur_addr == 16'h4000, "R2 wrap to start", cur_addr, 16'h4000);
        load(16'h5FFF, 16'd100);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);

        // R7 window edges
        load(16'd31, 16'd50);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        load(16'h3FFF, 16'd50);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        load(16'h3FFF, 16'd50);
        port_op(1'b0, 1'b0, 1'b1, 32'h0);
        load(16'hBFFF, 16'd50);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);
        port_op(1'b0, 1'b1, 1'b0, 32'h0);
        load(16'h0020, 16'd50);
        port_op(1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF);

        // R3 count boundaries
        load(16'h4100, 16'd2);
        port_op(1'b1, 1'b0, 1'b1, 32'h0000_5A5A);
        load(16'h4100, 16'd3);
        port_op(1'b0, 1'b1, 1'b0, 32'h0);
        load(16'h4100, 16'd5);
        port_op(1'b0, 1'b0, 1'b0, 32'h0);

        // R11 load wins over a same-cycle access; R9 one-cycle valid
        load(16'h4100, 16'd10);
        @(negedge clk);
        cfg_word16 = 1'b0; acc_valid = 1'b1; acc_write = 1'b0; acc_wide = 1'b0;
        ld_addr = 1'b1; ld_addr_val = 16'h4200;
        @(negedge clk);
        acc_valid = 1'b0; ld_addr = 1'b0;
        chk(cur_addr == 16'h4200, "R11 load priority addr", cur_addr, 16'h4200);
        chk(cur_cnt == 16'd9, "R11 count still stepped", cur_cnt, 9);
        chk(rd_valid == 1'b1, "R9 valid after read", rd_valid, 1);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R9 valid one cycle", rd_valid, 0);
        e_addr = 16'h4200; e_cnt = 16'd9;

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0)
                load(16'($urandom_range(16'h4000, 16'h5FFF)), 16'($urandom_range(0, 40)));
            else if (r == 1)
                load(16'($urandom_range(0, 16'hFFFF)), 16'($urandom_range(0, 40)));
            else
                port_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), $urandom);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule